// File: doc/BRIEF.md
# Dwell Pointer Queue Manager

Inside one downlink beam buffer, each arriving header subpacket names a destination dwell, or it carries a multicast mark. This block takes the pointer for that packet and appends it to the queue of the named dwell. A multicast packet ignores its dwell field, and its single pointer is appended to every dwell queue. No data is copied. The pointer is an index into an address control memory, and that memory holds the data address. So each queue entry works as the first half of a double pointer.

Each dwell owns two queues that work as ping-pong banks. A frame-start strobe swaps the banks. Writes for the current frame go to one bank while the other bank drains the previous frame. Draining runs in dwell order: the lowest-numbered dwell that still holds entries is served first, in arrival order, until its queue is empty. Each dwell also raises a congestion flag once its filling queue reaches a programmable threshold below full. This warns of trouble before entries are lost. A write that finds its queue full is dropped and latches a sticky overflow flag.

Top module: `dwell_ptr_queue`

## Requirements
- R1: A write with `wr_mcast` low appends `wr_ptr` (12 bits) only to the queue of the dwell whose number is given by the 3-bit `wr_dwell` field, in the current write bank.
- R2: A write with `wr_mcast` high ignores `wr_dwell` and appends the same `wr_ptr` to the queues of all 8 dwells in the write bank.
- R3: Each queue holds `DEPTH` entries (default 16). A write to a full queue is dropped for that dwell, and it sets that dwell's bit of `ovf`. That bit stays set until reset.
- R4: After reset the write bank is bank 0. Each `frame_start` pulse swaps the write bank and the read bank. Entries written before the pulse become readable in the cycle after it.
- R5: `rd_valid` is high when any read-bank queue holds an entry. `rd_dwell` is the lowest-numbered dwell with entries, and `rd_ptr` is the oldest entry of that dwell. Asserting `rd_req` while `rd_valid` is high removes that entry. Asserting `rd_req` while `rd_valid` is low has no effect.
- R6: `cong[d]` is high whenever the write-bank fill of dwell d is at least `cfg_thresh`. The flag follows a write from the next cycle onward.
- R7: At a `frame_start` pulse, the bank that becomes the write bank is emptied and its unread entries are discarded. A write or a read taken in the pulse cycle acts on the banks as they were before the swap.
- R8: After reset all queues are empty, `rd_valid` is low, and `ovf` is all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_start | input | 1 | Frame boundary strobe that swaps banks |
| wr_en | input | 1 | Header pointer write |
| wr_mcast | input | 1 | Multicast mark: write to all dwells |
| wr_dwell | input | 3 | Destination dwell number |
| wr_ptr | input | 12 | Pointer into the address control memory |
| cfg_thresh | input | 5 | Congestion fill threshold |
| rd_req | input | 1 | Pop the presented entry |
| rd_valid | output | 1 | Read bank holds an entry |
| rd_dwell | output | 3 | Dwell of the presented entry |
| rd_ptr | output | 12 | Presented pointer |
| cong | output | 8 | Per-dwell congestion flag |
| ovf | output | 8 | Per-dwell sticky overflow flag |

## Verification
A write or pop taken at a rising edge changes the queue fills at that edge. `cong` and `ovf` follow in the same cycle, after the edge. The presented read entry (`rd_valid`, `rd_dwell`, `rd_ptr`) depends only on registered state, so a pop or a swap shows at the read port right after the edge that took it. The bench drives every input at the falling edge, samples all outputs one time unit later, and updates its own queue model at the rising edge. Each sample is therefore compared with the model state that the previous edge produced.

// File: rtl/dwell_ptr_queue.sv
module dwell_ptr_queue #(
  parameter int NUM_DWELL = 8,
  parameter int PTR_W     = 12,
  parameter int DEPTH     = 16,
  localparam int DW_W  = $clog2(NUM_DWELL),
  localparam int IDX_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 frame_start,
  input  logic                 wr_en,
  input  logic                 wr_mcast,
  input  logic [DW_W-1:0]      wr_dwell,
  input  logic [PTR_W-1:0]     wr_ptr,
  input  logic [CNT_W-1:0]     cfg_thresh,
  input  logic                 rd_req,
  output logic                 rd_valid,
  output logic [DW_W-1:0]      rd_dwell,
  output logic [PTR_W-1:0]     rd_ptr,
  output logic [NUM_DWELL-1:0] cong,
  output logic [NUM_DWELL-1:0] ovf
);

  logic                 wsel;
  logic                 rsel;
  logic [PTR_W-1:0]     mem  [2][NUM_DWELL][DEPTH];
  logic [IDX_W-1:0]     wp   [2][NUM_DWELL];
  logic [IDX_W-1:0]     rp   [2][NUM_DWELL];
  logic [CNT_W-1:0]     cnt  [2][NUM_DWELL];
  logic [NUM_DWELL-1:0] hit, full, push, busy;
  logic                 pop;

  assign rsel = ~wsel;
  assign pop  = rd_req && rd_valid;

  function automatic logic [IDX_W-1:0] nxt(input logic [IDX_W-1:0] x);
    return (x == IDX_W'(DEPTH - 1)) ? '0 : x + IDX_W'(1);
  endfunction

  always_comb begin
    for (int d = 0; d < NUM_DWELL; d++) begin
      hit[d]  = wr_en && (wr_mcast || wr_dwell == DW_W'(d));
      full[d] = cnt[wsel][d] == CNT_W'(DEPTH);
      push[d] = hit[d] && !full[d];
      busy[d] = cnt[rsel][d] != '0;
      cong[d] = cnt[wsel][d] >= cfg_thresh;
    end
  end

  always_comb begin
    rd_dwell = '0;
    for (int d = NUM_DWELL - 1; d >= 0; d--)
      if (busy[d]) rd_dwell = DW_W'(d);
  end

  assign rd_valid = |busy;
  assign rd_ptr   = mem[rsel][rd_dwell][rp[rsel][rd_dwell]];

  always_ff @(posedge clk) begin
    for (int d = 0; d < NUM_DWELL; d++)
      if (push[d]) mem[wsel][d][wp[wsel][d]] <= wr_ptr;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wsel <= 1'b0;
      ovf  <= '0;
      for (int b = 0; b < 2; b++)
        for (int d = 0; d < NUM_DWELL; d++) begin
          wp[b][d]  <= '0;
          rp[b][d]  <= '0;
          cnt[b][d] <= '0;
        end
    end else begin
      for (int d = 0; d < NUM_DWELL; d++) begin
        if (push[d]) wp[wsel][d] <= nxt(wp[wsel][d]);
        cnt[wsel][d] <= cnt[wsel][d] + CNT_W'(push[d]);
        if (hit[d] && full[d]) ovf[d] <= 1'b1;
        if (pop && rd_dwell == DW_W'(d)) begin
          rp[rsel][d]  <= nxt(rp[rsel][d]);
          cnt[rsel][d] <= cnt[rsel][d] - CNT_W'(1);
        end
        if (frame_start) begin
          wp[rsel][d]  <= '0;
          rp[rsel][d]  <= '0;
          cnt[rsel][d] <= '0;
        end
      end
      if (frame_start) wsel <= ~wsel;
    end
  end

  generate
    for (genvar g = 0; g < NUM_DWELL; g++) begin : g_chk
      p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cnt[0][g] <= CNT_W'(DEPTH) && cnt[1][g] <= CNT_W'(DEPTH));
      p_ovf_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ovf[g] |=> ovf[g]);
      p_mcast_all_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_mcast && !frame_start)
        |=> (cnt[wsel][g] == $past(cnt[wsel][g]) + CNT_W'(1)) || ovf[g]);
      p_unicast_only_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_mcast && wr_dwell != DW_W'(g) && !frame_start)
        |=> cnt[wsel][g] == $past(cnt[wsel][g]));
      p_read_bank_frozen_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_start |=> cnt[rsel][g] <= $past(cnt[rsel][g]));
      p_swap_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |=> cnt[wsel][g] == '0);
    end
  endgenerate

endmodule

// File: tb/sim_dwell_ptr_queue.sv
module sim_dwell_ptr_queue;
  localparam int CLK_PERIOD = 10;
  localparam int ND = 8;
  localparam int DEP = 16;

  logic clk = 0, rst_n = 0, frame_start = 0, wr_en = 0, wr_mcast = 0, rd_req = 0;
  logic [2:0] wr_dwell = 0;
  logic [11:0] wr_ptr = 0;
  logic [4:0] cfg_thresh = 5'd12;
  logic rd_valid;
  logic [2:0] rd_dwell;
  logic [11:0] rd_ptr;
  logic [7:0] cong, ovf;

  int checks = 0, fails = 0;
  bit finished = 0;
  string ph = "R1";

  logic [11:0] mq [2][ND][DEP];
  int mn [2][ND];
  bit mw;
  logic [7:0] movf;

  always #(CLK_PERIOD/2) clk = ~clk;

  dwell_ptr_queue u0 (.clk, .rst_n, .frame_start, .wr_en, .wr_mcast, .wr_dwell,
    .wr_ptr, .cfg_thresh, .rd_req, .rd_valid, .rd_dwell, .rd_ptr, .cong, .ovf);

  task automatic chk(input bit ok, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", what, act, exp);
    end
  endtask

  function automatic int exp_dwell();
    for (int d = 0; d < ND; d++) if (mn[!mw][d] > 0) return d;
    return -1;
  endfunction

  function automatic logic [7:0] exp_cong();
    logic [7:0] c;
    for (int d = 0; d < ND; d++) c[d] = mn[mw][d] >= int'(cfg_thresh);
    return c;
  endfunction

  task automatic check_outputs();
    int ed;
    ed = exp_dwell();
    chk(rd_valid == (ed >= 0), "R5 rd_valid", rd_valid, ed >= 0);
    if (ed >= 0) begin
      chk(rd_dwell == 3'(ed), {ph, " rd_dwell"}, rd_dwell, ed);
      chk(rd_ptr == mq[!mw][ed][0], {ph, " rd_ptr"}, rd_ptr, mq[!mw][ed][0]);
    end
    chk(cong == exp_cong(), "R6 cong", cong, exp_cong());
    chk(ovf == movf, "R3 ovf", ovf, movf);
  endtask

  task automatic model_update(bit fs, bit we, logic [11:0] p, int dw, bit mc, bit rq);
    int ed;
    ed = exp_dwell();
    if (we)
      for (int d = 0; d < ND; d++)
        if (mc || d == dw) begin
          if (mn[mw][d] == DEP) movf[d] = 1'b1;
          else begin mq[mw][d][mn[mw][d]] = p; mn[mw][d]++; end
        end
    if (rq && ed >= 0) begin
      for (int i = 0; i < DEP - 1; i++) mq[!mw][ed][i] = mq[!mw][ed][i+1];
      mn[!mw][ed]--;
    end
    if (fs) begin
      for (int d = 0; d < ND; d++) mn[!mw][d] = 0;
      mw = !mw;
    end
  endtask

  task automatic step(bit fs, bit we, logic [11:0] p, int dw, bit mc, bit rq);
    @(negedge clk);
    frame_start = fs; wr_en = we; wr_ptr = p; wr_dwell = 3'(dw); wr_mcast = mc; rd_req = rq;
    #1 check_outputs();
    @(posedge clk);
    model_update(fs, we, p, dw, mc, rq);
  endtask

  task automatic drain(int n);
    for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, 1);
  endtask

  initial begin
    for (int c = 0; c < 200000; c++) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    mw = 0; movf = 0;
    for (int b = 0; b < 2; b++) for (int d = 0; d < ND; d++) mn[b][d] = 0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;
    // R8 reset state
    #1 chk(!rd_valid && ovf == 0 && cong == 0, "R8 reset state", {rd_valid, ovf}, 0);
    // R1 unicast ordering, R4 swap visibility
    ph = "R1";
    step(0, 1, 12'h0A5, 5, 0, 0);
    step(0, 1, 12'h3C2, 2, 0, 1);
    step(0, 1, 12'hFFF, 5, 0, 0);
    ph = "R4";
    step(1, 0, 0, 0, 0, 0);
    drain(4);
    // R2 multicast ignores dwell field
    ph = "R2";
    step(0, 1, 12'h777, 6, 1, 0);
    step(0, 1, 12'h123, 1, 0, 0);
    step(1, 0, 0, 0, 0, 0);
    drain(10);
    // R3 overflow on dwell 3, R6 threshold
    ph = "R3";
    cfg_thresh = 5'd4;
    for (int i = 0; i < DEP + 2; i++) step(0, 1, 12'(i + 100), 3, 0, 0);
    // R7 unread entries discarded, strobe-cycle write lands pre-swap
    ph = "R7";
    step(1, 1, 12'h555, 0, 0, 1);
    drain(3);
    step(1, 0, 0, 0, 0, 0);
    step(1, 0, 0, 0, 0, 0);
    drain(2);
    // random traffic
    ph = "R5";
    for (int f = 0; f < 60; f++) begin
      cfg_thresh = 5'($urandom_range(1, 16));
      step(1, $urandom_range(0, 3) == 0, 12'($urandom), $urandom_range(0, 7), 0, $urandom_range(0, 1));
      for (int k = 0; k < $urandom_range(5, 40); k++)
        step(0, $urandom_range(0, 9) < 6, 12'($urandom), $urandom_range(0, 7),
             $urandom_range(0, 9) < 2, $urandom_range(0, 1));
    end
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule